// File: doc/BRIEF.md
# Reordering Stream Fetch Buffer

This block sits between a tensor engine's operand stream and a multi-banked scratchpad. Each read request it issues carries a tag, which is the index of a slot reserved in a small circular reorder buffer. Banks answer after different delays depending on how far away they are: 3, 5 or 9 cycles. Answers can therefore return in any order. Each answer is written into the slot named by its tag. The engine sees the data strictly in the order the requests were issued, through a ready/valid output that is 512 bits wide by default.

The block also holds a separate first-word-fall-through FIFO for the engine's result stream. This FIFO lets the engine run on while write-back is stalled. One instance serves one operand stream, and an engine with three operand streams uses three instances. `ROB_DEPTH` and `Z_DEPTH` must be powers of two.

Top module: `sfb_stream_fetch`

## Requirements
- R1: After reset, no slot is in use. `out_valid` is 0, `rd_tag` is 0, `z_empty` is 1 and `z_full` is 0.
- R2: `rd_issue` is 1 exactly when `rd_go` is 1 and a slot is free. Tags are handed out in circular order 0,1,…,ROB_DEPTH-1,0, and `rd_tag` moves forward by one after each issue.
- R3: No more than ROB_DEPTH (16) requests are ever outstanding. With 16 outstanding, `rd_issue` stays 0 even when `rd_go` is 1.
- R4: Responses may arrive in any order and with any mix of 3, 5 and 9 cycle delays. `out_data` still delivers each response's data in the order of its request.
- R5: `out_valid` rises only when the oldest outstanding slot holds its response. This happens the cycle after that response is accepted on the response port.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` unchanged.
- R7: A response whose tag names a slot with no outstanding request is ignored. It creates no output and does not overwrite data for a later request in that slot.
- R8: The result FIFO holds Z_DEPTH (32) entries. It returns them in push order with the head visible on `z_rdata`, and `z_full` is 1 exactly when it holds 32 entries.
- R9: A push while `z_full` is 1 is dropped, and a pop while `z_empty` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_go | input | 1 | Address generator wants to issue a read |
| rd_issue | output | 1 | Read issued this cycle |
| rd_tag | output | $clog2(ROB_DEPTH) | Slot tag attached to the read |
| rsp_valid | input | 1 | Bank response present |
| rsp_tag | input | $clog2(ROB_DEPTH) | Tag of the response |
| rsp_data | input | DW | Response data |
| out_valid | output | 1 | In-order data available to the engine |
| out_ready | input | 1 | Engine accepts data |
| out_data | output | DW | In-order data |
| z_push | input | 1 | Write a result beat |
| z_wdata | input | DW | Result beat |
| z_full | output | 1 | Result FIFO full |
| z_pop | input | 1 | Remove head result beat |
| z_rdata | output | DW | Head result beat |
| z_empty | output | 1 | Result FIFO empty |

## Verification
The bench mixes 9, 3 and 5 cycle delays so that younger requests regularly overtake older ones. A design that released data as it arrived, instead of in request order, would send beats out of order to the scoreboard. The bench holds responses back until all 16 slots are taken and keeps requesting. A design that kept issuing would reuse a live tag and lose data. A stray response is sent to the next slot to be handed out, before that slot is used. A design that accepted it would raise `out_valid` with junk before the real answer arrives. Long stretches of `out_ready` low catch data changing under backpressure. The result FIFO is pushed past full and popped past empty, which exposes count corruption.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
package sfb_pkg;
  // Occupancy of a ring whose pointers run over 0..span-1 (span = 2*depth)
  function automatic int unsigned ring_dist(int unsigned wr, int unsigned rd,
                                            int unsigned span);
    return (wr + span - rd) % span;
  endfunction

  // True when the occupancy has reached the ring capacity
  function automatic bit ring_full(int unsigned used, int unsigned depth);
    return used >= depth;
  endfunction
endpackage

// File: rtl/sfb_rob.sv
`timescale 1ns/1ps
module sfb_rob #(
  parameter int DEPTH = 16,
  parameter int DW    = 512,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PW    = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_go,
  output logic             req_fire,
  output logic [TAG_W-1:0] req_tag,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic [DW-1:0]    rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data
);
  logic [PW-1:0]    wr_q, rd_q, used;
  logic [DEPTH-1:0] pend_q, done_q;
  logic [DW-1:0]    slot_mem [DEPTH];
  logic [TAG_W-1:0] head, tail;
  logic             slots_full, rsp_take, out_fire;

  assign head       = rd_q[TAG_W-1:0];
  assign tail       = wr_q[TAG_W-1:0];
  assign used       = PW'(sfb_pkg::ring_dist(int'(wr_q), int'(rd_q), 2 * DEPTH));
  assign slots_full = sfb_pkg::ring_full(int'(used), DEPTH);
  assign req_fire   = req_go && !slots_full;
  assign req_tag    = tail;
  assign rsp_take   = rsp_valid && pend_q[rsp_tag] && !done_q[rsp_tag];
  assign out_valid  = done_q[head];
  assign out_fire   = out_valid && out_ready;
  assign out_data   = slot_mem[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      pend_q <= '0;
      done_q <= '0;
    end else begin
      if (req_fire) begin
        wr_q         <= wr_q + 1'b1;
        pend_q[tail] <= 1'b1;
      end
      if (rsp_take) done_q[rsp_tag] <= 1'b1;
      if (out_fire) begin
        rd_q         <= rd_q + 1'b1;
        pend_q[head] <= 1'b0;
        done_q[head] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_take) slot_mem[rsp_tag] <= rsp_data;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
  p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> req_tag == TAG_W'($past(req_tag) + 1'b1));
  p_head_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend_q[head]);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_stray_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !pend_q[rsp_tag] && !out_fire) |=> $stable(done_q));
endmodule

// File: rtl/sfb_zfifo.sv
`timescale 1ns/1ps
module sfb_zfifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  logic [PW-1:0] wr_q, rd_q, level;
  logic [DW-1:0] mem [DEPTH];
  logic          push_ok, pop_ok;

  assign level   = PW'(sfb_pkg::ring_dist(int'(wr_q), int'(rd_q), 2 * DEPTH));
  assign full    = sfb_pkg::ring_full(int'(level), DEPTH);
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q[AW-1:0]] <= wdata;
  end

  p_full_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> (!empty && $stable(rdata)));
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/sfb_stream_fetch.sv
`timescale 1ns/1ps
module sfb_stream_fetch #(
  parameter int ROB_DEPTH = 16,
  parameter int Z_DEPTH   = 32,
  parameter int DW        = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_go,
  output logic                         rd_issue,
  output logic [$clog2(ROB_DEPTH)-1:0] rd_tag,
  input  logic                         rsp_valid,
  input  logic [$clog2(ROB_DEPTH)-1:0] rsp_tag,
  input  logic [DW-1:0]                rsp_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DW-1:0]                out_data,
  input  logic                         z_push,
  input  logic [DW-1:0]                z_wdata,
  output logic                         z_full,
  input  logic                         z_pop,
  output logic [DW-1:0]                z_rdata,
  output logic                         z_empty
);
  sfb_rob #(.DEPTH(ROB_DEPTH), .DW(DW)) rob_i (
    .clk(clk), .rst_n(rst_n),
    .req_go(rd_go), .req_fire(rd_issue), .req_tag(rd_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  sfb_zfifo #(.DEPTH(Z_DEPTH), .DW(DW)) zfifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(z_push), .wdata(z_wdata), .full(z_full),
    .pop(z_pop), .rdata(z_rdata), .empty(z_empty)
  );
endmodule

// File: tb/sfb_stream_fetch_tb_top.sv
`timescale 1ns/1ps
module sfb_stream_fetch_tb_top;
  localparam int DW    = 512;
  localparam int DEPTH = 16;
  localparam int ZD    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_go = 1'b0, rd_issue;
  logic [3:0]    rd_tag;
  logic          rsp_valid = 1'b0;
  logic [3:0]    rsp_tag = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          z_push = 1'b0, z_pop = 1'b0, z_full, z_empty;
  logic [DW-1:0] z_wdata = '0, z_rdata;

  always #2.5 clk = ~clk;

  sfb_stream_fetch #(.ROB_DEPTH(DEPTH), .Z_DEPTH(ZD), .DW(DW)) dut_i (.*);

  int checks = 0, errors = 0;
  int cyc = 0, seq = 0, issued = 0;
  int go_mode = 0, go_left = 0, rdy_mode = 0;
  bit hold_rsp = 1'b0, last_sent = 1'b0, hold_pend = 1'b0;
  logic [DW-1:0] hold_data;
  logic [3:0]    exp_tag = '0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] tag_data [DEPTH];
  int            rq_tag[$], rq_due[$];
  logic [DW-1:0] zq[$];
  int            lat_tab [3] = '{9, 3, 5};

  function automatic logic [DW-1:0] mk(int s);
    return {16{32'(32'hC0DE0000 + s)}};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one cycle of driver + monitor, inputs set at negedge, handshakes sampled after settle
  task automatic step();
    @(negedge clk);
    cyc++;
    rsp_valid = 1'b0;
    last_sent = 1'b0;
    if (!hold_rsp) begin
      for (int i = 0; i < rq_tag.size(); i++) begin
        if (rq_due[i] <= cyc) begin
          rsp_valid = 1'b1;
          rsp_tag   = 4'(rq_tag[i]);
          rsp_data  = tag_data[rq_tag[i]];
          rq_tag.delete(i);
          rq_due.delete(i);
          last_sent = 1'b1;
          break;
        end
      end
    end
    case (go_mode)
      1:       rd_go = (go_left > 0);
      2:       rd_go = (go_left > 0) && (($urandom % 4) != 0);
      default: rd_go = 1'b0;
    endcase
    case (rdy_mode)
      1:       out_ready = 1'b1;
      2:       out_ready = (($urandom % 3) != 0);
      default: out_ready = 1'b0;
    endcase
    #1;
    if (hold_pend)  // R6
      chk(out_valid && out_data == hold_data, "R6 hold", out_data, hold_data);
    hold_pend = out_valid && !out_ready;
    hold_data = out_data;
    if (rd_go && rd_issue) begin
      chk(rd_tag == exp_tag, "R2 tag order", DW'(rd_tag), DW'(exp_tag));
      tag_data[rd_tag] = mk(seq);
      sb.push_back(mk(seq));
      rq_tag.push_back(int'(rd_tag));
      rq_due.push_back(cyc + lat_tab[seq % 3]);
      exp_tag = exp_tag + 1'b1;
      seq++;
      issued++;
      go_left--;
    end else if (rd_go) begin
      chk(sb.size() >= DEPTH, "R2 issue when free", DW'(rd_issue), DW'(1));
    end
    if (out_valid && out_ready) begin
      if (sb.size() == 0) chk(1'b0, "R4 unexpected beat", out_data, '0);
      else begin
        chk(out_data == sb[0], "R4 in-order data", out_data, sb[0]);
        void'(sb.pop_front());
      end
    end
  endtask

  task automatic drain();
    go_mode = 0;
    for (int g = 0; g < 600 && (sb.size() > 0); g++) step();
    chk(sb.size() == 0, "R4 all delivered", DW'(sb.size()), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", DW'(out_valid), '0);
    chk(rd_tag == '0, "R1 rd_tag", DW'(rd_tag), '0);
    chk(z_empty == 1'b1, "R1 z_empty", DW'(z_empty), DW'(1));
    chk(z_full == 1'b0, "R1 z_full", DW'(z_full), '0);
    chk(rd_issue == 1'b0, "R1 no issue when idle", DW'(rd_issue), '0);

    // R5: single request, output one cycle after response
    go_mode = 1; go_left = 1; rdy_mode = 1;
    for (int g = 0; g < 40; g++) begin
      step();
      if (last_sent) break;
      chk(out_valid == 1'b0, "R5 no early valid", DW'(out_valid), '0);
    end
    chk(out_valid == 1'b0, "R5 not same cycle", DW'(out_valid), '0);
    step();
    chk(out_valid == 1'b1, "R5 valid next cycle", DW'(out_valid), DW'(1));
    drain();

    // R4/R6 mixed traffic
    go_mode = 2; go_left = 1000000; rdy_mode = 2;
    repeat (300) step();
    drain();

    // R3: fill all slots with responses held back
    hold_rsp = 1'b1; go_mode = 1; go_left = 1000000; rdy_mode = 1;
    issued = 0;
    repeat (24) step();
    chk(issued == DEPTH, "R3 sixteen outstanding", DW'(issued), DW'(DEPTH));
    chk(rd_go && !rd_issue, "R3 no issue when full", DW'(rd_issue), '0);
    chk(out_valid == 1'b0, "R5 nothing before responses", DW'(out_valid), '0);
    go_mode = 0;
    hold_rsp = 1'b0; rdy_mode = 0;
    repeat (20) step();
    chk(out_valid == 1'b1, "R6 held under backpressure", DW'(out_valid), DW'(1));
    rdy_mode = 2;
    drain();

    // R7: stray response to the next slot to be handed out
    hold_rsp = 1'b1; rdy_mode = 1;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = exp_tag; rsp_data = {16{32'hDEADBEEF}};
    go_mode = 1; go_left = 1;
    repeat (4) begin
      step();
      chk(out_valid == 1'b0, "R7 stray ignored", DW'(out_valid), '0);
    end
    hold_rsp = 1'b0;
    drain();

    // R4 heavy streaming
    go_mode = 1; go_left = 1000000; rdy_mode = 1;
    repeat (200) step();
    drain();
    rdy_mode = 0;

    // R8/R9 result FIFO
    for (int i = 0; i < ZD; i++) begin
      @(negedge clk);
      z_push = 1'b1; z_wdata = mk(1000 + i); zq.push_back(mk(1000 + i));
    end
    @(negedge clk);
    z_push = 1'b0;
    #1;
    chk(z_full == 1'b1, "R8 full at 32", DW'(z_full), DW'(1));
    chk(z_rdata == zq[0], "R8 head visible", z_rdata, zq[0]);
    @(negedge clk);
    z_push = 1'b1; z_wdata = mk(7777);
    @(negedge clk);
    z_push = 1'b0;
    #1;
    chk(z_full == 1'b1, "R9 push when full dropped", DW'(z_full), DW'(1));
    for (int i = 0; i < ZD; i++) begin
      @(negedge clk);
      #1;
      chk(z_rdata == zq[0], "R8 pop order", z_rdata, zq[0]);
      void'(zq.pop_front());
      z_pop = 1'b1;
      @(negedge clk);
      z_pop = 1'b0;
    end
    #1;
    chk(z_empty == 1'b1, "R9 empty after all pops, dropped push absent", DW'(z_empty), DW'(1));
    @(negedge clk);
    z_pop = 1'b1;
    @(negedge clk);
    z_pop = 1'b0; z_push = 1'b1; z_wdata = mk(4242);
    @(negedge clk);
    z_push = 1'b0;
    #1;
    chk(z_empty == 1'b0, "R9 pop when empty ignored", DW'(z_empty), '0);
    chk(z_rdata == mk(4242), "R9 head after empty pop", z_rdata, mk(4242));
    z_pop = 1'b1;
    @(negedge clk);
    z_pop = 1'b0;
    #1;
    chk(z_empty == 1'b1, "R8 empty after last pop", DW'(z_empty), DW'(1));

    finish_up();
  end
endmodule